// File: doc/BRIEF.md
# ADC Sample Sequence Controller

The controller walks an analog-to-digital converter through a short programmed list of conversions. It holds up to four steps. Each step is described by four bits of a 16-bit control word and by a 4-bit channel nibble. A trigger pulse starts the list at step 0. For each step the controller offers one conversion request to the converter and waits for the converter's completion pulse. It stops after the first step whose end flag is set. Steps after that one are never offered, whatever their bits hold.

Each step can select a single-ended pin, a differential pair or the on-die temperature sensor. Each step can also ask for an interrupt when its conversion completes. The interrupt is held in a raw flag that software clears with a one-cycle clear strobe. A mask input decides whether the raw flag reaches the interrupt output. Configuration mistakes and triggers that arrive while a list is running are recorded in sticky flags, which only reset clears.

The request path uses a valid/ready handshake. While `req_valid` is high and `req_ready` is low, the request and its fields do not change. A request is accepted on a clock edge where both signals are high. The converter then signals completion with a one-cycle `conv_done`. No new request is raised until that pulse arrives.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Step k of the control word sits in bits [4k+3:4k] as {temp, irq_en, last, diff}, with temp the most significant bit. Its channel nibble is bits [4k+3:4k] of the mux register. A plain step (temp=0, diff=0) requests `req_chan` equal to its nibble, with `req_diff`=0 and `req_temp`=0.
- R2: A step with temp=1 requests `req_temp`=1, `req_diff`=0 and `req_chan`=0. If the same step also has diff=1, it still samples the sensor single-ended, and `cfg_err` is set once that step's request is accepted.
- R3: A step with diff=1 and temp=0 requests `req_diff`=1, and `req_chan` carries the pair index i taken from the nibble. Pair i means inputs 2i and 2i+1.
- R4: The list ends after the lowest-numbered step with last=1. No later step is requested, and `busy` is low in the cycle after that step's `conv_done`.
- R5: If no step has last=1, all four steps run and `cfg_err` is set once step 3's request is accepted.
- R6: `raw_irq` is set in the cycle after the `conv_done` of any step with irq_en=1. More than one step may set it. It stays set until an `irq_clr` pulse clears it, and a set in the same cycle as a clear wins.
- R7: `irq` equals `raw_irq` AND `int_mask`.
- R8: A trigger while `busy` is high does not restart or change the running list, and it sets the sticky `overrun` flag.
- R9: While `req_valid` is high and `req_ready` is low, `req_valid` and the request fields hold steady. After a request is accepted, `req_valid` stays low until `conv_done` arrives.
- R10: `cfg_rdata` returns the control word in bits [15:0] and zero in bits [31:16], whatever was written there. Writes to the control or mux register while `busy` is high are ignored.
- R11: After reset, the control word, mux register, `raw_irq`, `irq`, `cfg_err`, `overrun`, `busy` and `req_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word write data (upper half discarded) |
| cfg_rdata | output | 32 | Control word readback, upper half zero |
| mux_wr | input | 1 | Write strobe for the channel nibbles |
| mux_wdata | input | 16 | Four channel nibbles, step k in bits [4k+3:4k] |
| int_mask | input | 1 | Forwards raw interrupt to `irq` when high |
| irq_clr | input | 1 | One-cycle clear of `raw_irq` |
| trig | input | 1 | Starts a list when idle |
| req_valid | output | 1 | Conversion request offered |
| req_ready | input | 1 | Converter accepts the request |
| req_chan | output | 4 | Pin number or pair index |
| req_diff | output | 1 | Differential conversion |
| req_temp | output | 1 | Temperature sensor conversion |
| conv_done | input | 1 | Converter finished the accepted request |
| busy | output | 1 | A list is running |
| raw_irq | output | 1 | Sticky raw interrupt |
| irq | output | 1 | Masked interrupt |
| cfg_err | output | 1 | Sticky configuration error |
| overrun | output | 1 | Sticky trigger-while-busy flag |

## Verification
A trigger raises `req_valid` one edge later. An accepted request drops `req_valid` at the edge of acceptance. A `conv_done` updates `raw_irq`, `busy` and the next step's request at that same edge. `cfg_err` follows the accepting edge, and `overrun` follows the edge on which the trigger is seen. The bench drives every input at the falling edge and reads every output at the next falling edge, so each result is compared exactly one register stage after its cause. Before raising `req_ready`, the bench also holds it low for a cycle to see that the offered request stays put.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;

  // Per-step control bits, msb first
  typedef struct packed {
    logic temp;
    logic irq_en;
    logic last;
    logic diff;
  } step_cfg_t;
endpackage

// File: rtl/adc_seq_step_sel.sv
module adc_seq_step_sel
  import adc_seq_pkg::*;
#(
  parameter int NSTEP = 4,
  parameter int CHW   = 4,
  localparam int IDXW = $clog2(NSTEP)
) (
  input  logic [4*NSTEP-1:0]   ctl,
  input  logic [CHW*NSTEP-1:0] mux,
  input  logic [IDXW-1:0]      idx,
  output logic [CHW-1:0]       chan,
  output logic                 diff,
  output logic                 temp,
  output logic                 irq_en,
  output logic                 last_eff,
  output logic                 err_step
);
  step_cfg_t          cur;
  logic [CHW-1:0]     nib;
  logic               final_pos;

  assign cur       = step_cfg_t'(ctl[4*idx +: 4]);
  assign nib       = mux[CHW*idx +: CHW];
  assign final_pos = (idx == IDXW'(NSTEP-1));

  // Sensor wins over differential; illegal combination degrades to single-ended
  assign temp     = cur.temp;
  assign diff     = cur.diff & ~cur.temp;
  assign chan     = cur.temp ? '0 : nib;
  assign irq_en   = cur.irq_en;
  assign last_eff = cur.last | final_pos;
  assign err_step = (cur.temp & cur.diff) | (final_pos & ~cur.last);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NSTEP = 4,
  localparam int IDXW = $clog2(NSTEP)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  input  logic            req_ready,
  input  logic            conv_done,
  input  logic            last_eff,
  output logic [IDXW-1:0] idx,
  output logic            busy,
  output logic            req_valid,
  output logic            accept,
  output logic            step_done
);
  seq_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (trig) begin
          state <= ST_REQ;
          idx   <= '0;
        end
        ST_REQ:  if (req_ready) state <= ST_WAIT;
        ST_WAIT: if (conv_done) begin
          if (last_eff) begin
            state <= ST_IDLE;
          end else begin
            state <= ST_REQ;
            idx   <= idx + IDXW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign req_valid = (state == ST_REQ);
  assign accept    = req_valid & req_ready;
  assign step_done = (state == ST_WAIT) & conv_done;
endmodule

// File: rtl/adc_seq_status.sv
module adc_seq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_set,
  input  logic irq_clr,
  input  logic int_mask,
  input  logic ovr_set,
  input  logic err_set,
  output logic raw_irq,
  output logic irq,
  output logic overrun,
  output logic cfg_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_irq <= 1'b0;
      overrun <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      if (irq_set)      raw_irq <= 1'b1;
      else if (irq_clr) raw_irq <= 1'b0;
      if (ovr_set) overrun <= 1'b1;
      if (err_set) cfg_err <= 1'b1;
    end
  end

  assign irq = raw_irq & int_mask;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NSTEP = 4,
  parameter int CHW   = 4,
  localparam int CTLW = 4*NSTEP,
  localparam int MUXW = CHW*NSTEP,
  localparam int IDXW = $clog2(NSTEP)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic            mux_wr,
  input  logic [MUXW-1:0] mux_wdata,
  input  logic            int_mask,
  input  logic            irq_clr,
  input  logic            trig,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [CHW-1:0]  req_chan,
  output logic            req_diff,
  output logic            req_temp,
  input  logic            conv_done,
  output logic            busy,
  output logic            raw_irq,
  output logic            irq,
  output logic            cfg_err,
  output logic            overrun
);
  logic [CTLW-1:0] ctl_q;
  logic [MUXW-1:0] mux_q;
  logic [IDXW-1:0] idx;
  logic            irq_en, last_eff, err_step, accept, step_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      mux_q <= '0;
    end else if (!busy) begin
      if (cfg_wr) ctl_q <= cfg_wdata[CTLW-1:0];
      if (mux_wr) mux_q <= mux_wdata;
    end
  end

  assign cfg_rdata = {{(32-CTLW){1'b0}}, ctl_q};

  adc_seq_step_sel #(.NSTEP(NSTEP), .CHW(CHW)) u_sel (
    .ctl(ctl_q), .mux(mux_q), .idx(idx),
    .chan(req_chan), .diff(req_diff), .temp(req_temp),
    .irq_en(irq_en), .last_eff(last_eff), .err_step(err_step)
  );

  adc_seq_fsm #(.NSTEP(NSTEP)) u_fsm (
    .clk(clk), .rst_n(rst_n), .trig(trig), .req_ready(req_ready),
    .conv_done(conv_done), .last_eff(last_eff), .idx(idx), .busy(busy),
    .req_valid(req_valid), .accept(accept), .step_done(step_done)
  );

  adc_seq_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .irq_set(step_done & irq_en), .irq_clr(irq_clr), .int_mask(int_mask),
    .ovr_set(trig & busy), .err_set(accept & err_step),
    .raw_irq(raw_irq), .irq(irq), .overrun(overrun), .cfg_err(cfg_err)
  );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [31:0] cfg_rdata,
  input logic        trig,
  input logic        req_valid,
  input logic        req_ready,
  input logic [3:0]  req_chan,
  input logic        req_diff,
  input logic        req_temp,
  input logic        conv_done,
  input logic        busy,
  input logic        raw_irq,
  input logic        overrun
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31:16] == 16'h0);                                           // R10
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cfg_wr |=> $stable(cfg_rdata));                               // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_chan)
      && $stable(req_diff) && $stable(req_temp));                         // R9
  AST_WAIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid);                               // R9
  AST_TEMP_SE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_temp |-> !req_diff && req_chan == 4'd0);             // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);                                                // R4
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_irq) |-> $past(conv_done));                                 // R6
  AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    trig && busy |=> overrun);                                            // R8
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rdata(cfg_rdata),
  .trig(trig), .req_valid(req_valid), .req_ready(req_ready),
  .req_chan(req_chan), .req_diff(req_diff), .req_temp(req_temp),
  .conv_done(conv_done), .busy(busy), .raw_irq(raw_irq), .overrun(overrun)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, mux_wr = 1'b0, int_mask = 1'b0, irq_clr = 1'b0;
  logic        trig = 1'b0, req_ready = 1'b0, conv_done = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [15:0] mux_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  req_chan;
  logic        req_valid, req_diff, req_temp, busy, raw_irq, irq, cfg_err, overrun;
  int          n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .mux_wr(mux_wr), .mux_wdata(mux_wdata),
    .int_mask(int_mask), .irq_clr(irq_clr), .trig(trig),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .req_diff(req_diff), .req_temp(req_temp), .conv_done(conv_done),
    .busy(busy), .raw_irq(raw_irq), .irq(irq), .cfg_err(cfg_err),
    .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input int v);
    logic [15:0] ctl, mux;
    bit exp_raw, exp_err, mask, do_ovr, do_wr;
    int last;
    ctl    = 16'((v * 40503) ^ (v << 5));
    mux    = 16'((v * 7919) ^ 16'h3c5a);
    mask   = v[0] ^ v[3];
    do_ovr = (v % 4 == 1);
    do_wr  = (v % 4 == 2);
    last = 3; exp_err = 1'b1;
    for (int k = 3; k >= 0; k--) if (ctl[4*k+1]) begin last = k; exp_err = 1'b0; end
    exp_raw = 1'b0;
    for (int k = 0; k <= last; k++) begin
      if (ctl[4*k+3] && ctl[4*k]) exp_err = 1'b1;
      if (ctl[4*k+2]) exp_raw = 1'b1;
    end
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cfg_wr = 1'b1; cfg_wdata = {16'ha5c3, ctl}; mux_wr = 1'b1; mux_wdata = mux;
    int_mask = mask;
    @(negedge clk); cfg_wr = 1'b0; mux_wr = 1'b0;
    check(cfg_rdata == {16'h0, ctl}, "R10", "readback", cfg_rdata, {16'h0, ctl});
    trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    for (int k = 0; k <= last; k++) begin
      logic [3:0] e_chan;
      bit e_t, e_d;
      int guard;
      e_t    = ctl[4*k+3];
      e_d    = ctl[4*k] & ~e_t;
      e_chan = e_t ? 4'd0 : mux[4*k +: 4];
      guard  = 0;
      while (!req_valid && guard < 20) begin @(negedge clk); guard++; end
      check(req_valid && req_chan == e_chan && req_diff == e_d && req_temp == e_t,
            e_t ? "R2" : (e_d ? "R3" : "R1"), "request",
            {req_valid, req_temp, req_diff, req_chan}, {1'b1, e_t, e_d, e_chan});
      @(negedge clk);
      check(req_valid && req_chan == e_chan, "R9", "hold", {req_valid, req_chan},
            {1'b1, e_chan});
      req_ready = 1'b1;
      @(negedge clk); req_ready = 1'b0;
      if (k == 0 && do_ovr) trig = 1'b1;
      if (k == 0 && do_wr) begin cfg_wr = 1'b1; cfg_wdata = {16'h0, ~ctl}; end
      @(negedge clk); trig = 1'b0; cfg_wr = 1'b0;
      check(!req_valid, "R9", "no request before done", req_valid, 0);
      conv_done = 1'b1;
      @(negedge clk); conv_done = 1'b0;
    end
    for (int c = 0; c < 4; c++) begin
      check(!req_valid && !busy, "R4", "idle after last step", {req_valid, busy}, 0);
      @(negedge clk);
    end
    check(cfg_err == exp_err, exp_err && last == 3 ? "R5" : "R2", "cfg_err", cfg_err, exp_err);
    check(raw_irq == exp_raw, "R6", "raw_irq", raw_irq, exp_raw);
    check(irq == (exp_raw & mask), "R7", "irq", irq, exp_raw & mask);
    check(overrun == do_ovr, "R8", "overrun", overrun, do_ovr);
    check(cfg_rdata == {16'h0, ctl}, "R10", "write while busy", cfg_rdata, ctl);
    irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    check(!raw_irq && !irq, "R6", "clear", raw_irq, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(cfg_rdata == 0 && !busy && !req_valid && !raw_irq && !irq && !cfg_err
          && !overrun, "R11", "reset state",
          {cfg_rdata[3:0], busy, req_valid, raw_irq, irq, cfg_err, overrun}, 0);
    rst_n = 1'b1;
    for (int v = 0; v < 1500; v++) run_vec(v);
    // R6: a set in the same cycle as a clear wins
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; cfg_wr = 1'b1; cfg_wdata = 32'h0006;
    @(negedge clk); cfg_wr = 1'b0; trig = 1'b1;
    @(negedge clk); trig = 1'b0; req_ready = 1'b1;
    @(negedge clk); req_ready = 1'b0; conv_done = 1'b1; irq_clr = 1'b1;
    @(negedge clk); conv_done = 1'b0; irq_clr = 1'b0;
    check(raw_irq, "R6", "set beats clear", raw_irq, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule